// File: doc/BRIEF.md
# Asynchronous Character Receiver with Match Detection

This block recovers characters from an asynchronous serial line. A 16x oversampling enable (`tick_i`) paces all line sampling. The receiver qualifies a start bit at its centre, then samples each data bit, the optional parity bit and the stop bits at their centres. Each finished character goes into a holding register, together with its error flags and a per-slot match vector. The character length, stop-bit count and parity mode are read when a start bit is detected. They stay fixed for the rest of that character.

The holding register raises a one-cycle strobe and keeps `avail_o` high until the consumer pulses `rd_i`. If a second character finishes while the first is still unread, the first character is kept and an overrun flag is raised. Every accepted character is compared against a bank of programmable match characters. Each slot has its own enable, and only the configured number of data bits take part in the comparison. A line held low through the data bits, the parity bit and the first stop bit is reported as a break, not as an ordinary character.

Top module: `async_rx_matcher`

## Requirements
- R1: A falling line level starts a character only if the line is still low at the 8th tick after detection. Otherwise the receiver returns to idle and produces no character.
- R2: `len_sel_i` selects the character length as 5 + code bits (0→5, 1→6, 2→7, 3→8). Bits are received LSB first, and `data_o` bits at or above the length read zero.
- R3: With `par_en_i` high, one parity bit follows the data. The parity is even when `par_odd_i` is 0 and odd when it is 1. `par_err_o` is set when the received parity bit disagrees.
- R4: `stop_sel_i` selects 1 stop bit (code 0), 1.5 stop bits (code 1) or 2 stop bits (codes 2 and 3). `frm_err_o` is set when any sampled stop bit is low.
- R5: When all data bits, the parity bit (if enabled) and the first stop bit are sampled low, `brk_o` is set, and `frm_err_o`, `par_err_o` and all match hits read zero. The receiver then waits for the line to go high before it accepts a new start bit.
- R6: A character that finishes while `avail_o` is high and `rd_i` is low sets `ovr_o`, leaves `data_o` and the flags of the earlier character unchanged, and produces no strobe.
- R7: When `rd_i` is high in the same cycle that a character finishes, the new character is accepted: `ovr_o` stays 0, `avail_o` stays 1 and the strobe fires.
- R8: `hit_o[i]` is set when `match_en_i[i]` is 1 and the low (5 + `len_sel_i`) bits of match slot i (`match_chars_i[8*i+7:8*i]`) equal the received character. `match_o` is the OR of the hits.
- R9: `strobe_o` is high for exactly one cycle per accepted character, and `avail_o` stays high until `rd_i` clears it.
- R10: After reset, `avail_o`, `strobe_o`, `ovr_o`, all error flags and all hits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 16x oversampling enable |
| rxd_i | input | 1 | Serial line input, idle high |
| len_sel_i | input | 2 | Character length code (5 + code bits) |
| stop_sel_i | input | 2 | Stop bits: 0 = 1, 1 = 1.5, 2/3 = 2 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| match_chars_i | input | N_MATCH*DATA_W | Match characters, slot i in bits [8i+7:8i] |
| match_en_i | input | N_MATCH | Per-slot match enable |
| rd_i | input | 1 | Consumer read acknowledge |
| strobe_o | output | 1 | One-cycle pulse for a newly accepted character |
| avail_o | output | 1 | Holding register contains an unread character |
| data_o | output | DATA_W | Received character |
| par_err_o | output | 1 | Parity error |
| frm_err_o | output | 1 | Framing error |
| brk_o | output | 1 | Break detected |
| ovr_o | output | 1 | A later character was lost |
| hit_o | output | N_MATCH | Per-slot match hits |
| match_o | output | 1 | Any slot matched |

## Verification
A consumer read and the completion of the next character can land on the same clock edge. In that case the read must release the old character and the new one must be loaded, with no overrun. The bench first measures the exact latency from the start edge to the strobe for a fixed configuration and tick phase. It then leaves one character unread, replays the same timing for a second character, and raises `rd_i` only in the cycle just before the predicted strobe. The result passes when the strobe appears on the predicted cycle, the new character is present and `ovr_o` is 0. A separate run, with no read at all, must keep the first character and set `ovr_o`.

// File: rtl/arx_pkg.sv
package arx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2,
      ST_WAIT_HIGH
   } arx_state_e;

   typedef struct packed {
      logic par_err;
      logic frm_err;
      logic brk;
   } arx_flags_t;

   localparam logic [1:0] STOP_ONE      = 2'd0;
   localparam logic [1:0] STOP_ONE_HALF = 2'd1;
   localparam int unsigned MIN_CHAR_BITS = 5;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/arx_sampler.sv
module arx_sampler
   import arx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic [1:0]        len_sel_i,
   input  logic [1:0]        stop_sel_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output arx_flags_t        flags_o,
   output logic [1:0]        len_o
);
   localparam int unsigned CW       = $clog2(OVERSAMPLE);
   localparam int unsigned IW       = $clog2(DATA_W);
   localparam logic [CW-1:0] MID_PT  = CW'(OVERSAMPLE / 2 - 1);
   localparam logic [CW-1:0] FULL_PT = CW'(OVERSAMPLE - 1);
   localparam logic [CW-1:0] QTR_PT  = CW'((OVERSAMPLE * 3) / 4 - 1);

   arx_state_e        state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     bit_idx;
   logic [DATA_W-1:0] shreg;
   logic [1:0]        len_q;
   logic [1:0]        stop_q;
   logic              pen_q;
   logic              podd_q;
   logic              par_acc;
   logic              par_bad;
   logic              all_low;
   logic              frm_seen;

   logic [IW-1:0]     last_idx;
   logic [CW-1:0]     stop2_pt;
   logic              at_full;
   logic              brk_at_stop1;

   always_comb begin
      last_idx     = IW'({1'b0, len_q}) + IW'(MIN_CHAR_BITS - 1);
      stop2_pt     = (stop_q == STOP_ONE_HALF) ? QTR_PT : FULL_PT;
      at_full      = (cnt == FULL_PT);
      brk_at_stop1 = all_low & ~rxd_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         len_q    <= '0;
         stop_q   <= '0;
         pen_q    <= 1'b0;
         podd_q   <= 1'b0;
         par_acc  <= 1'b0;
         par_bad  <= 1'b0;
         all_low  <= 1'b0;
         frm_seen <= 1'b0;
         done_o   <= 1'b0;
         flags_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            unique case (state)
               ST_IDLE: begin
                  if (!rxd_i) begin
                     state  <= ST_START;
                     cnt    <= '0;
                     len_q  <= len_sel_i;
                     stop_q <= stop_sel_i;
                     pen_q  <= par_en_i;
                     podd_q <= par_odd_i;
                  end
               end
               ST_START: begin
                  if (cnt == MID_PT) begin
                     cnt <= '0;
                     if (rxd_i) begin
                        state <= ST_IDLE;
                     end else begin
                        state    <= ST_DATA;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        par_bad  <= 1'b0;
                        all_low  <= 1'b1;
                        frm_seen <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_full) begin
                     cnt            <= '0;
                     shreg[bit_idx] <= rxd_i;
                     par_acc        <= par_acc ^ rxd_i;
                     all_low        <= all_low & ~rxd_i;
                     if (bit_idx == last_idx) state <= pen_q ? ST_PAR : ST_STOP1;
                     else                     bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_full) begin
                     cnt     <= '0;
                     par_bad <= par_acc ^ rxd_i ^ podd_q;
                     all_low <= all_low & ~rxd_i;
                     state   <= ST_STOP1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP1: begin
                  if (at_full) begin
                     cnt <= '0;
                     if (stop_q == STOP_ONE) begin
                        done_o          <= 1'b1;
                        flags_o.brk     <= brk_at_stop1;
                        flags_o.frm_err <= ~rxd_i & ~brk_at_stop1;
                        flags_o.par_err <= par_bad & ~brk_at_stop1;
                        state           <= brk_at_stop1 ? ST_WAIT_HIGH : ST_IDLE;
                     end else begin
                        frm_seen <= ~rxd_i;
                        all_low  <= brk_at_stop1;
                        state    <= ST_STOP2;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP2: begin
                  if (cnt == stop2_pt) begin
                     cnt             <= '0;
                     done_o          <= 1'b1;
                     flags_o.brk     <= all_low;
                     flags_o.frm_err <= (frm_seen | ~rxd_i) & ~all_low;
                     flags_o.par_err <= par_bad & ~all_low;
                     state           <= all_low ? ST_WAIT_HIGH : ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WAIT_HIGH: begin
                  if (rxd_i) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign data_o = shreg;
   assign len_o  = len_q;
endmodule

// File: rtl/arx_matcher.sv
module arx_matcher
   import arx_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_MATCH = 4
) (
   input  logic [DATA_W-1:0]         data_i,
   input  logic [1:0]                len_i,
   input  logic [N_MATCH*DATA_W-1:0] chars_i,
   input  logic [N_MATCH-1:0]        en_i,
   output logic [N_MATCH-1:0]        hit_o
);
   logic [DATA_W-1:0] mask;

   for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      assign mask[b] = (b < (int'(len_i) + MIN_CHAR_BITS));
   end

   for (genvar s = 0; s < N_MATCH; s++) begin : g_slot
      logic [DATA_W-1:0] ref_char;
      assign ref_char = chars_i[s*DATA_W +: DATA_W];
      assign hit_o[s] = en_i[s] && ((ref_char & mask) == (data_i & mask));
   end
endmodule

// File: rtl/arx_holding.sv
module arx_holding
   import arx_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_MATCH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done_i,
   input  logic [DATA_W-1:0]  data_i,
   input  arx_flags_t         flags_i,
   input  logic [N_MATCH-1:0] hit_i,
   input  logic               rd_i,
   output logic               strobe_o,
   output logic               avail_o,
   output logic [DATA_W-1:0]  data_o,
   output arx_flags_t         flags_o,
   output logic               ovr_o,
   output logic [N_MATCH-1:0] hit_o,
   output logic               any_o
);
   logic              busy;
   logic [N_MATCH-1:0] hit_gated;

   assign busy      = avail_o & ~rd_i;
   assign hit_gated = flags_i.brk ? '0 : hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_o <= 1'b0;
         avail_o  <= 1'b0;
         data_o   <= '0;
         flags_o  <= '0;
         ovr_o    <= 1'b0;
         hit_o    <= '0;
         any_o    <= 1'b0;
      end else begin
         strobe_o <= 1'b0;
         if (done_i && busy) begin
            ovr_o <= 1'b1;
         end else if (done_i) begin
            strobe_o <= 1'b1;
            avail_o  <= 1'b1;
            data_o   <= data_i;
            flags_o  <= flags_i;
            ovr_o    <= 1'b0;
            hit_o    <= hit_gated;
            any_o    <= |hit_gated;
         end else if (rd_i) begin
            avail_o <= 1'b0;
            ovr_o   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/async_rx_matcher.sv
module async_rx_matcher
   import arx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned N_MATCH     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_i,
   input  logic                       rxd_i,
   input  logic [1:0]                 len_sel_i,
   input  logic [1:0]                 stop_sel_i,
   input  logic                       par_en_i,
   input  logic                       par_odd_i,
   input  logic [N_MATCH*DATA_W-1:0]  match_chars_i,
   input  logic [N_MATCH-1:0]         match_en_i,
   input  logic                       rd_i,
   output logic                       strobe_o,
   output logic                       avail_o,
   output logic [DATA_W-1:0]          data_o,
   output logic                       par_err_o,
   output logic                       frm_err_o,
   output logic                       brk_o,
   output logic                       ovr_o,
   output logic [N_MATCH-1:0]         hit_o,
   output logic                       match_o
);
   if (OVERSAMPLE < 8 || (OVERSAMPLE % 4) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be a multiple of 4 and at least 8");
   end
   if (DATA_W != 8) begin : g_bad_w
      $error("DATA_W must be 8: length codes select 5 to 8 bits");
   end
   if (N_MATCH < 1 || N_MATCH > 16) begin : g_bad_n
      $error("N_MATCH must be between 1 and 16");
   end
   if (SYNC_STAGES < 1) begin : g_bad_s
      $error("SYNC_STAGES must be at least 1");
   end

   logic              rxd_s;
   logic              done;
   logic [DATA_W-1:0] smp_data;
   arx_flags_t        smp_flags;
   arx_flags_t        out_flags;
   logic [1:0]        smp_len;
   logic [N_MATCH-1:0] raw_hits;

   arx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rxd_s)
   );

   arx_sampler #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) i_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .rxd_i      (rxd_s),
      .len_sel_i  (len_sel_i),
      .stop_sel_i (stop_sel_i),
      .par_en_i   (par_en_i),
      .par_odd_i  (par_odd_i),
      .done_o     (done),
      .data_o     (smp_data),
      .flags_o    (smp_flags),
      .len_o      (smp_len)
   );

   arx_matcher #(.DATA_W(DATA_W), .N_MATCH(N_MATCH)) i_matcher (
      .data_i  (smp_data),
      .len_i   (smp_len),
      .chars_i (match_chars_i),
      .en_i    (match_en_i),
      .hit_o   (raw_hits)
   );

   arx_holding #(.DATA_W(DATA_W), .N_MATCH(N_MATCH)) i_holding (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (done),
      .data_i   (smp_data),
      .flags_i  (smp_flags),
      .hit_i    (raw_hits),
      .rd_i     (rd_i),
      .strobe_o (strobe_o),
      .avail_o  (avail_o),
      .data_o   (data_o),
      .flags_o  (out_flags),
      .ovr_o    (ovr_o),
      .hit_o    (hit_o),
      .any_o    (match_o)
   );

   assign par_err_o = out_flags.par_err;
   assign frm_err_o = out_flags.frm_err;
   assign brk_o     = out_flags.brk;
endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_MATCH = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_i,
   input logic               strobe_o,
   input logic               avail_o,
   input logic [DATA_W-1:0]  data_o,
   input logic               par_err_o,
   input logic               frm_err_o,
   input logic               brk_o,
   input logic               ovr_o,
   input logic [N_MATCH-1:0] hit_o
);
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   a_r9_strobe_with_avail: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> avail_o);

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_o && rd_i) |=> (!avail_o || strobe_o));

   a_r6_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_o && !rd_i) |=> $stable(data_o));

   a_r6_ovr_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> avail_o);

   a_r5_brk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_o && brk_o) |-> (!frm_err_o && !par_err_o && hit_o == '0));
endmodule

bind async_rx_matcher arx_checker #(.DATA_W(DATA_W), .N_MATCH(N_MATCH)) i_arx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_i      (rd_i),
   .strobe_o  (strobe_o),
   .avail_o   (avail_o),
   .data_o    (data_o),
   .par_err_o (par_err_o),
   .frm_err_o (frm_err_o),
   .brk_o     (brk_o),
   .ovr_o     (ovr_o),
   .hit_o     (hit_o)
);

// File: tb/test_async_rx_matcher.sv
`timescale 1ns/1ps
module test_async_rx_matcher;
   localparam int NM = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rxd = 1'b1;
   logic [1:0]  len_sel = 2'd3;
   logic [1:0]  stop_sel = 2'd0;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic [31:0] mchars = '0;
   logic [3:0]  men = '0;
   logic        rd = 1'b0;
   logic        strobe, avail, par_err, frm_err, brk, ovr, match_any;
   logic [7:0]  data;
   logic [3:0]  hits;
   logic        tick;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   int cur_idx, rd_at_g, strobe_at_g;
   int strobe_total = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && strobe) strobe_total <= strobe_total + 1;
   end
   assign tick = (cyc % 3 == 0);

   async_rx_matcher i_async_rx_matcher (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
      .len_sel_i(len_sel), .stop_sel_i(stop_sel), .par_en_i(par_en),
      .par_odd_i(par_odd), .match_chars_i(mchars), .match_en_i(men),
      .rd_i(rd), .strobe_o(strobe), .avail_o(avail), .data_o(data),
      .par_err_o(par_err), .frm_err_o(frm_err), .brk_o(brk), .ovr_o(ovr),
      .hit_o(hits), .match_o(match_any)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] len_mask(input logic [1:0] l);
      return 8'((9'd1 << (5 + l)) - 9'd1);
   endfunction

   function automatic logic good_par(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic hold_line(input logic v, input int n);
      for (int i = 0; i < n; i++) begin
         rxd = v;
         rd  = (cur_idx == rd_at_g);
         @(negedge clk);
         cur_idx++;
         if (strobe && strobe_at_g < 0) strobe_at_g = cur_idx;
      end
      rd = 1'b0;
   endtask

   // par_mode: 0 correct, 1 inverted, 2 forced low
   task automatic send_frame(input logic [7:0] d, input int par_mode,
                             input logic s1, input logic s2, input int rd_at);
      logic [7:0] dm;
      logic pbit;
      dm = d & len_mask(len_sel);
      pbit = (par_mode == 2) ? 1'b0 : (good_par(dm, par_odd) ^ (par_mode == 1));
      @(negedge clk);
      while (cyc % 3 != 0) @(negedge clk);
      cur_idx = 0; rd_at_g = rd_at; strobe_at_g = -1;
      hold_line(1'b0, 48);
      for (int i = 0; i < 5 + int'(len_sel); i++) hold_line(dm[i], 48);
      if (par_en) hold_line(pbit, 48);
      hold_line(s1, 48);
      if (stop_sel == 2'd1) hold_line(s2, 24);
      else if (stop_sel >= 2'd2) hold_line(s2, 48);
      hold_line(1'b1, 96);
   endtask

   task automatic do_read();
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic check_char(input logic [7:0] d, input int par_mode,
                             input logic s1, input logic s2, input string tag);
      logic [7:0] dm;
      logic pbit, e_brk, e_frm, e_par;
      logic [3:0] e_hit;
      dm = d & len_mask(len_sel);
      pbit = (par_mode == 2) ? 1'b0 : (good_par(dm, par_odd) ^ (par_mode == 1));
      e_brk = (dm == 8'd0) && (!par_en || pbit == 1'b0) && !s1;
      e_frm = !e_brk && (!s1 || (stop_sel != 2'd0 && !s2));
      e_par = !e_brk && par_en && (pbit != good_par(dm, par_odd));
      for (int i = 0; i < NM; i++)
         e_hit[i] = !e_brk && men[i] &&
                    ((mchars[8*i +: 8] & len_mask(len_sel)) == dm);
      chk(avail == 1'b1, {tag, " R9 avail"}, avail, 1);
      chk(data == dm, {tag, " R2 data"}, data, dm);
      chk(par_err == e_par, {tag, " R3 parity"}, par_err, e_par);
      chk(frm_err == e_frm, {tag, " R4 framing"}, frm_err, e_frm);
      chk(brk == e_brk, {tag, " R5 break"}, brk, e_brk);
      chk(hits == e_hit && match_any == |e_hit, {tag, " R8 match"}, {match_any, hits}, {|e_hit, e_hit});
      chk(ovr == 1'b0, {tag, " R6 no overrun"}, ovr, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int lat, sc;
      logic [7:0] d;
      int pm;
      logic s1, s2;
      void'($urandom(32'd5150));
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(avail == 0 && strobe == 0 && ovr == 0, "R10 reset status", {avail, strobe, ovr}, 0);
      chk(par_err == 0 && frm_err == 0 && brk == 0, "R10 reset flags", {par_err, frm_err, brk}, 0);
      chk(hits == 0 && match_any == 0, "R10 reset hits", hits, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R1 glitch shorter than half a bit
      sc = strobe_total;
      @(negedge clk); while (cyc % 3 != 0) @(negedge clk);
      rxd = 1'b0; repeat (9) @(negedge clk);
      rxd = 1'b1; repeat (200) @(negedge clk);
      chk(avail == 0 && strobe_total == sc, "R1 glitch rejected", avail, 0);

      // R2/R8 short char, match char differs only above length
      len_sel = 2'd0; par_en = 1'b0; stop_sel = 2'd0;
      mchars = {8'h00, 8'h00, 8'hE5, 8'h00}; men = 4'b0010;
      send_frame(8'h05, 0, 1'b1, 1'b1, -1);
      check_char(8'h05, 0, 1'b1, 1'b1, "short");
      do_read();
      chk(avail == 0, "R9 read clears", avail, 0);

      // R8 enable off suppresses an equal character
      len_sel = 2'd3; mchars = {8'h3C, 8'h3C, 8'h3C, 8'h3C}; men = 4'b0101;
      send_frame(8'h3C, 0, 1'b1, 1'b1, -1);
      check_char(8'h3C, 0, 1'b1, 1'b1, "enables");
      do_read();

      // R4 1.5 stop with low second stop
      stop_sel = 2'd1; par_en = 1'b1; par_odd = 1'b1;
      send_frame(8'hA7, 0, 1'b1, 1'b0, -1);
      check_char(8'hA7, 0, 1'b1, 1'b0, "half stop");
      do_read();

      // R5 break with parity, two stops; then a normal char
      stop_sel = 2'd2; par_odd = 1'b0; men = 4'b1111; mchars = '0;
      send_frame(8'h00, 2, 1'b0, 1'b0, -1);
      check_char(8'h00, 2, 1'b0, 1'b0, "break");
      do_read();
      send_frame(8'h81, 0, 1'b1, 1'b1, -1);
      check_char(8'h81, 0, 1'b1, 1'b1, "after break");
      do_read();

      // R6 overrun keeps first character
      len_sel = 2'd3; par_en = 1'b0; stop_sel = 2'd0; men = 4'b0;
      sc = strobe_total;
      send_frame(8'h11, 0, 1'b1, 1'b1, -1);
      send_frame(8'h22, 0, 1'b1, 1'b1, -1);
      chk(avail && ovr, "R6 overrun flag", {avail, ovr}, 3);
      chk(data == 8'h11, "R6 first char kept", data, 8'h11);
      chk(strobe_total == sc + 1, "R6 single strobe", strobe_total - sc, 1);
      do_read();
      chk(!avail && !ovr, "R6 read clears overrun", {avail, ovr}, 0);

      // R7 read in the same cycle as completion (calibrate first)
      send_frame(8'h5A, 0, 1'b1, 1'b1, -1);
      lat = strobe_at_g;
      do_read();
      chk(lat > 1, "R9 strobe observed", lat, 1);
      send_frame(8'h33, 0, 1'b1, 1'b1, -1);
      send_frame(8'h44, 0, 1'b1, 1'b1, lat - 1);
      chk(strobe_at_g == lat, "R7 strobe on predicted cycle", strobe_at_g, lat);
      chk(avail && !ovr && data == 8'h44, "R7 new char accepted", {ovr, data}, 8'h44);
      do_read();

      // Random mix
      for (int it = 0; it < 40; it++) begin
         len_sel  = 2'($urandom % 4);
         stop_sel = 2'($urandom % 4);
         par_en   = 1'($urandom % 2);
         par_odd  = 1'($urandom % 2);
         mchars   = $urandom;
         men      = 4'($urandom);
         d        = 8'($urandom);
         pm       = ($urandom % 5 == 0) ? 1 : 0;
         s1       = ($urandom % 6 != 0);
         s2       = ($urandom % 6 != 0);
         if ($urandom % 3 == 0) mchars[8*($urandom % 4) +: 8] = d ^ (8'($urandom) & ~len_mask(len_sel));
         if ($urandom % 10 == 0) begin d = 8'h00; pm = 2; s1 = 1'b0; s2 = 1'b0; end
         send_frame(d, pm, s1, s2, -1);
         check_char(d, pm, s1, s2, "random");
         do_read();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule